// File: doc/BRIEF.md
# USB Host Command, Status and Interrupt Register Group

This block holds the command, status and interrupt-enable registers of a full/low-speed USB host controller. Software reaches it through a small word-addressed register port with a combinational read path and a single-cycle write strobe. The command register drives the controller's run/stop state, a bus-wide device reset, global suspend, forced resume and the maximum packet size choice. A configure flag is also kept there for software's own use.

A transaction engine reports events on single-cycle pulse inputs: completed transfers (with an interrupt-on-completion tag and a short-packet flag), transaction errors, resume detection, host system errors and controller process errors. Each event sets a sticky status bit, and software clears that bit by writing a 1 to it. One interrupt line is raised while any maskable status bit is set together with its enable bit, or while either unmaskable error bit is set. Writing the controller-reset command bit returns the whole group to its reset state one cycle later.

Top module: `usb_hc_regs`

## Requirements
- R1: After reset the command register (address 0) reads 0x00, the status register (address 1) reads 0x20, the enable register (address 2) reads 0x00, and every control output and irq are 0.
- R2: Command bit 0 is run/stop and drives runStop. Status bit 5 (halted) reads 1 in every cycle in which command bit 0 is 0, and reads 0 otherwise. It cannot be written.
- R3: Command bit 2 drives busReset, bit 3 drives globalSuspend, bit 4 drives forceResume, and bit 7 drives maxPkt64 (1 selects 64-byte packets, 0 selects 32-byte packets). Each follows the stored bit in the cycle after the write.
- R4: Command bit 6 is a configure flag that reads back as written and changes no output. Command bit 5 always reads 0.
- R5: A command write with bit 1 set makes bit 1 read 1 for exactly one cycle. At the next clock edge all three registers return to their R1 values and bit 1 clears. Writes and events in that cycle are dropped.
- R6: A pulse on evDone sets status bit 0 only when evIoc is also 1. It sets status bit 6 (short packet) only when evShort is also 1.
- R7: evError sets status bit 1, evResume sets bit 2, evSysErr sets bit 3 and evProcErr sets bit 4.
- R8: Status bits 0-4 and 6 stay set until a status write with a 1 in that position clears them. A 0 in that position leaves the bit unchanged. An event on the same edge as its clear leaves the bit set.
- R9: The enable register keeps bits 3:0: bit 0 enables errors, bit 1 resume, bit 2 completion and bit 3 short packets. Bits 7:4 read 0.
- R10: irq is 1 exactly when (sts0 and en2) or (sts1 and en0) or (sts2 and en1) or (sts6 and en3) or sts3 or sts4.
- R11: Address 3 reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address for read and write |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| evDone | input | 1 | Transfer completed (pulse) |
| evIoc | input | 1 | Completed transfer is tagged interrupt-on-completion |
| evShort | input | 1 | Completed transfer was a short packet |
| evError | input | 1 | Transaction error (pulse) |
| evResume | input | 1 | Resume detected (pulse) |
| evSysErr | input | 1 | Host system error (pulse) |
| evProcErr | input | 1 | Controller process error (pulse) |
| runStop | output | 1 | Run (1) / stop (0) |
| busReset | output | 1 | Reset to all devices on the bus |
| globalSuspend | output | 1 | Global suspend request |
| forceResume | output | 1 | Forced global resume |
| maxPkt64 | output | 1 | 1: 64-byte max packet, 0: 32-byte |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that status bits only fall through a write-one-to-clear, that a cleared bit really drops, that untagged completions never set the completion bit, that the controller-reset bit clears itself and restores defaults, and that irq stays low when nothing can raise it. Other behaviour needs a scenario, and the bench's scenarios show it. Read-back of the configure flag with no effect on outputs needs one. So does an event beating its own clear on the same edge. The one-cycle visibility of the reset bit and the drop of writes to the unused address also need scenarios. The exact irq function across random enable and event mixes is compared against the reference model on every clock.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CMD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN = 2'd2;

  // command bit positions
  localparam int CMD_RUN    = 0;
  localparam int CMD_HCRST  = 1;
  localparam int CMD_BUSRST = 2;
  localparam int CMD_SUSP   = 3;
  localparam int CMD_RESUME = 4;
  localparam int CMD_CFG    = 6;
  localparam int CMD_PKT64  = 7;

  // status bit positions
  localparam int STS_IOC   = 0;
  localparam int STS_ERR   = 1;
  localparam int STS_RSM   = 2;
  localparam int STS_SYS   = 3;
  localparam int STS_PROC  = 4;
  localparam int STS_HALT  = 5;
  localparam int STS_SHORT = 6;

  // enable bit positions
  localparam int IEN_ERR   = 0;
  localparam int IEN_RSM   = 1;
  localparam int IEN_IOC   = 2;
  localparam int IEN_SHORT = 3;
  localparam int IEN_N     = 4;

  localparam logic [REG_W-1:0] CMD_MASK = REG_W'((1 << CMD_RUN) | (1 << CMD_HCRST) |
      (1 << CMD_BUSRST) | (1 << CMD_SUSP) | (1 << CMD_RESUME) | (1 << CMD_CFG) | (1 << CMD_PKT64));
  localparam logic [REG_W-1:0] STS_EV_MASK = REG_W'((1 << STS_IOC) | (1 << STS_ERR) |
      (1 << STS_RSM) | (1 << STS_SYS) | (1 << STS_PROC) | (1 << STS_SHORT));
  localparam logic [REG_W-1:0] STS_NOMASK = REG_W'((1 << STS_SYS) | (1 << STS_PROC));
  localparam logic [REG_W-1:0] IEN_MASK = REG_W'((1 << IEN_N) - 1);

  // status bit gated by each enable bit
  function automatic int ienSource(input int idx);
    case (idx)
      IEN_ERR:   return STS_ERR;
      IEN_RSM:   return STS_RSM;
      IEN_IOC:   return STS_IOC;
      default:   return STS_SHORT;
    endcase
  endfunction

  typedef struct packed {
    logic              wrCmd;
    logic              wrSts;
    logic              wrIen;
    logic              clearAll;
    logic [ADDR_W-1:0] rdSel;
    logic [REG_W-1:0]  setEv;
  } strobes_t;
endpackage

// File: rtl/usbhc_ctrl.sv
module usbhc_ctrl
  import usbhc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              hcRstBit,
  input  logic              evDone,
  input  logic              evIoc,
  input  logic              evShort,
  input  logic              evError,
  input  logic              evResume,
  input  logic              evSysErr,
  input  logic              evProcErr,
  output strobes_t          strobes
);
  logic [REG_W-1:0] evVec;

  always_comb begin
    evVec            = '0;
    evVec[STS_IOC]   = evDone & evIoc;
    evVec[STS_SHORT] = evDone & evShort;
    evVec[STS_ERR]   = evError;
    evVec[STS_RSM]   = evResume;
    evVec[STS_SYS]   = evSysErr;
    evVec[STS_PROC]  = evProcErr;
  end

  always_comb begin
    strobes.clearAll = hcRstBit;
    strobes.wrCmd    = regWrEn && (regAddr == ADDR_CMD);
    strobes.wrSts    = regWrEn && (regAddr == ADDR_STS);
    strobes.wrIen    = regWrEn && (regAddr == ADDR_IEN);
    strobes.rdSel    = regAddr;
    strobes.setEv    = evVec & STS_EV_MASK;
  end

  // R6: a completion without the tag never requests the completion bit
  a_r6_untagged_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (evDone && !evIoc) |-> !strobes.setEv[STS_IOC]);

  // R11: at most one register is selected for writing
  a_r11_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCmd, strobes.wrSts, strobes.wrIen}));
endmodule

// File: rtl/usbhc_regs.sv
module usbhc_regs
  import usbhc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             hcRstBit,
  output logic             runStop,
  output logic             busReset,
  output logic             globalSuspend,
  output logic             forceResume,
  output logic             maxPkt64,
  output logic             irq
);
  logic [REG_W-1:0] cmdQ, stsQ, ienQ;
  logic [REG_W-1:0] stsView;
  logic [REG_W-1:0] clrVec;
  logic [IEN_N-1:0] gated;

  assign clrVec = strobes.wrSts ? (wrData & STS_EV_MASK) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= '0;
      stsQ <= '0;
      ienQ <= '0;
    end else if (strobes.clearAll) begin
      cmdQ <= '0;
      stsQ <= '0;
      ienQ <= '0;
    end else begin
      if (strobes.wrCmd) cmdQ <= wrData & CMD_MASK;
      if (strobes.wrIen) ienQ <= wrData & IEN_MASK;
      stsQ <= (stsQ & ~clrVec) | strobes.setEv;
    end
  end

  always_comb begin
    stsView           = stsQ & STS_EV_MASK;
    stsView[STS_HALT] = ~cmdQ[CMD_RUN];
  end

  always_comb begin
    case (strobes.rdSel)
      ADDR_CMD: rdData = cmdQ;
      ADDR_STS: rdData = stsView;
      ADDR_IEN: rdData = ienQ;
      default:  rdData = '0;
    endcase
  end

  for (genvar g = 0; g < IEN_N; g++) begin : g_gate
    assign gated[g] = ienQ[g] & stsQ[ienSource(g)];
  end

  assign irq           = (|gated) | (|(stsQ & STS_NOMASK));
  assign hcRstBit      = cmdQ[CMD_HCRST];
  assign runStop       = cmdQ[CMD_RUN];
  assign busReset      = cmdQ[CMD_BUSRST];
  assign globalSuspend = cmdQ[CMD_SUSP];
  assign forceResume   = cmdQ[CMD_RESUME];
  assign maxPkt64      = cmdQ[CMD_PKT64];

  // R5: controller reset bit clears itself after one cycle
  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmdQ[CMD_HCRST] |=> !cmdQ[CMD_HCRST]);

  // R5: controller reset restores all defaults
  a_r5_defaults: assert property (@(posedge clk) disable iff (!rstN)
    cmdQ[CMD_HCRST] |=> (cmdQ == '0 && stsQ == '0 && ienQ == '0));

  // R8: without a status write or reset, no event bit falls
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.wrSts && !strobes.clearAll) |=> ((stsQ & $past(stsQ)) == $past(stsQ)));

  // R8: a written 1 clears the bit unless an event sets it on the same edge
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSts |=> ((stsQ & $past(wrData & ~strobes.setEv & STS_EV_MASK)) == '0));

  // R10: irq stays low when nothing is enabled and no unmaskable bit is set
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ienQ == '0 && (stsQ & STS_NOMASK) == '0) |-> !irq);
endmodule

// File: rtl/usb_hc_regs.sv
module usb_hc_regs
  import usbhc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              evDone,
  input  logic              evIoc,
  input  logic              evShort,
  input  logic              evError,
  input  logic              evResume,
  input  logic              evSysErr,
  input  logic              evProcErr,
  output logic              runStop,
  output logic              busReset,
  output logic              globalSuspend,
  output logic              forceResume,
  output logic              maxPkt64,
  output logic              irq
);
  strobes_t strobes;
  logic     hcRstBit;

  usbhc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .hcRstBit  (hcRstBit),
    .evDone    (evDone),
    .evIoc     (evIoc),
    .evShort   (evShort),
    .evError   (evError),
    .evResume  (evResume),
    .evSysErr  (evSysErr),
    .evProcErr (evProcErr),
    .strobes   (strobes)
  );

  usbhc_regs u_regs (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrData        (regWrData),
    .rdData        (regRdData),
    .hcRstBit      (hcRstBit),
    .runStop       (runStop),
    .busReset      (busReset),
    .globalSuspend (globalSuspend),
    .forceResume   (forceResume),
    .maxPkt64      (maxPkt64),
    .irq           (irq)
  );
endmodule

// File: tb/sim_usb_hc_regs.sv
`timescale 1ns/100ps
module sim_usb_hc_regs;
  logic       clk = 0;
  logic       rstN = 0;
  logic [1:0] regAddr = 0;
  logic       regWrEn = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic evDone = 0, evIoc = 0, evShort = 0, evError = 0;
  logic evResume = 0, evSysErr = 0, evProcErr = 0;
  logic runStop, busReset, globalSuspend, forceResume, maxPkt64, irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] mCmd = 0, mSts = 0, mEn = 0;

  always #2 clk = ~clk;

  usb_hc_regs u0 (.*);

  function automatic logic [7:0] mRead(input logic [1:0] a);
    case (a)
      2'd0: return mCmd;
      2'd1: return mSts | {2'b00, ~mCmd[0], 5'b0};
      2'd2: return mEn;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic mIrq();
    return (mSts[0] & mEn[2]) | (mSts[1] & mEn[0]) | (mSts[2] & mEn[1]) |
           (mSts[6] & mEn[3]) | mSts[3] | mSts[4];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCmd = 0; mSts = 0; mEn = 0;
    end else if (mCmd[1]) begin
      mCmd = 0; mSts = 0; mEn = 0;
    end else begin
      logic [7:0] ev;
      if (regWrEn && regAddr == 2'd0) mCmd = regWrData & 8'hDF;
      if (regWrEn && regAddr == 2'd2) mEn = regWrData & 8'h0F;
      if (regWrEn && regAddr == 2'd1) mSts = mSts & ~(regWrData & 8'h5F);
      ev = 0;
      if (evDone && evIoc) ev[0] = 1;
      if (evDone && evShort) ev[6] = 1;
      if (evError) ev[1] = 1;
      if (evResume) ev[2] = 1;
      if (evSysErr) ev[3] = 1;
      if (evProcErr) ev[4] = 1;
      mSts = mSts | ev;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, after inputs settle
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      chk("R10 irq", irq, mIrq());
      chk("R11 read", regRdData, mRead(regAddr));
      chk("R3 outputs", {runStop, busReset, globalSuspend, forceResume, maxPkt64},
          {mCmd[0], mCmd[2], mCmd[3], mCmd[4], mCmd[7]});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a;
    #0.5;
    chk(req, regRdData, exp);
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk);
    {evDone, evIoc, evShort, evError, evResume, evSysErr, evProcErr} = v;
    @(negedge clk);
    {evDone, evIoc, evShort, evError, evResume, evSysErr, evProcErr} = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rdChk("R1 cmd", 2'd0, 8'h00);
    rdChk("R1 sts", 2'd1, 8'h20);
    rdChk("R1 ien", 2'd2, 8'h00);
    chk("R1 irq", irq, 0);

    // R2 run/stop and halted flag, R3 packet select
    wr(2'd0, 8'h81);
    chk("R2 runStop", runStop, 1);
    chk("R3 maxPkt64", maxPkt64, 1);
    rdChk("R2 halted clear", 2'd1, 8'h00);
    wr(2'd0, 8'h1C);
    chk("R3 bus ctl", {busReset, globalSuspend, forceResume, maxPkt64}, 4'b1110);
    rdChk("R2 halted set", 2'd1, 8'h20);

    // R4 configure flag and reserved bit
    wr(2'd0, 8'h60);
    rdChk("R4 cfg readback", 2'd0, 8'h40);
    chk("R4 no output", {runStop, busReset, globalSuspend, forceResume, maxPkt64}, 5'b0);

    // R11 unused address
    wr(2'd3, 8'hFF);
    rdChk("R11 addr3", 2'd3, 8'h00);
    rdChk("R11 cmd kept", 2'd0, 8'h40);

    // R9 enable width
    wr(2'd2, 8'hF0);
    rdChk("R9 upper zero", 2'd2, 8'h00);

    // R6 completion gating
    pulse(7'b1000000);
    rdChk("R6 untagged", 2'd1, 8'h20);
    pulse(7'b1100000);
    rdChk("R6 tagged", 2'd1, 8'h21);
    pulse(7'b1010000);
    rdChk("R6 short", 2'd1, 8'h61);
    chk("R10 masked", irq, 0);

    // R7 other sources
    pulse(7'b0001000);
    pulse(7'b0000100);
    rdChk("R7 err+resume", 2'd1, 8'h67);
    chk("R10 still masked", irq, 0);
    wr(2'd2, 8'h02);
    chk("R10 resume enabled", irq, 1);

    // R8 write zero has no effect, write one clears
    wr(2'd1, 8'h00);
    rdChk("R8 write zero", 2'd1, 8'h67);
    wr(2'd1, 8'h04);
    rdChk("R8 clear resume", 2'd1, 8'h63);
    chk("R10 after clear", irq, 0);
    // event on the same edge as its clear
    @(negedge clk);
    regAddr = 2'd1; regWrEn = 1; regWrData = 8'h02; evError = 1;
    @(negedge clk);
    regWrEn = 0; evError = 0;
    rdChk("R8 event wins", 2'd1, 8'h63);

    pulse(7'b0000010);
    rdChk("R7 syserr", 2'd1, 8'h6B);
    chk("R10 unmaskable", irq, 1);
    pulse(7'b0000001);
    rdChk("R7 procerr", 2'd1, 8'h7B);

    // R5 controller reset
    wr(2'd2, 8'h0F);
    wr(2'd0, 8'hC3);
    rdChk("R5 bit visible", 2'd0, 8'hC3);
    @(negedge clk);
    rdChk("R5 cmd default", 2'd0, 8'h00);
    rdChk("R5 sts default", 2'd1, 8'h20);
    rdChk("R5 ien default", 2'd2, 8'h00);
    chk("R5 irq low", irq, 0);

    // random mix compared with the model each clock (R8 R10)
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      @(negedge clk);
      r = $urandom;
      regWrEn = (r[1:0] == 0);
      regAddr = r[3:2];
      regWrData = r[11:4];
      if (r[16:12] != 0) regWrData[1] = 0;
      evDone = r[17]; evIoc = r[18]; evShort = r[19];
      evError = (r[22:20] == 0); evResume = (r[25:23] == 0);
      evSysErr = (r[29:26] == 0); evProcErr = (r[31:28] == 1);
    end
    @(negedge clk);
    regWrEn = 0;
    {evDone, evIoc, evShort, evError, evResume, evSysErr, evProcErr} = 0;
    repeat (2) @(negedge clk);
    #1.5;
    summary();
  end
endmodule